// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is a two-address configuration port on a byte-wide I/O bus. The lower address (`bus_addr` = 0) is the index port and the upper address (`bus_addr` = 1) is the data port. After reset the port is closed. Software opens it by writing an unlock key twice in a row to the index port. Once open, an index write picks a register and data-port accesses read or write that register. Writing the lock key to the index port closes the port again.

Global registers (index below 0x30) hold a logical-device select, a device identifier, a revision, a vendor identifier and four pin-select bytes that software can read, modify and write. Registers at index 0x30 and above belong to the logical device named by the select register. The block holds each device's activate bit and 16-bit base address in its own bank. Any other index in device space is passed on to the function blocks as a write strobe, or read back from their `dev_rd_data` return. The bus has no back-pressure: every access is taken in the cycle it is presented, and the read result comes back exactly one cycle later with `bus_rvalid`. No valid/ready handshake is used.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the port is closed, the index is 0x00, the logical-device select is 0, every activate bit and base address is zero, and every pin-select byte is zero.
- R2: Two index-port writes of the unlock key (default 0x87), with no other bus write between them, open the port. Idle cycles between them are allowed. Any other index write, or any data-port write, between them cancels the first key.
- R3: While the port is open, an index-port write of the lock key (default 0xAA) closes it and leaves the index unchanged.
- R4: While the port is closed, data-port writes and index writes change no register, and reads of either address return 0xFF. While the port is open, a read of the index port returns the current index.
- R5: Index 0x07 is the logical-device select: it can be read and written, and its value drives `cur_ldn`.
- R6: Reads return the device ID high byte at 0x20, its low byte at 0x21, the revision at 0x22, the vendor ID high byte at 0x23 (default 0x19) and its low byte at 0x24 (default 0x34). Writes to these indices are ignored.
- R7: Index 0x30 of the selected device is its activate register. Only bit 0 is stored and bits 7:1 read 0. Bit n of `dev_act` is device n's activate bit, and each device keeps its own value.
- R8: Indices 0x60 (high byte) and 0x61 (low byte) of the selected device hold its base address, shown on `dev_base[16n+15:16n]`.
- R9: Indices 0x27, 0x29, 0x2A and 0x2B are read/write pin-select bytes, shown on `pin_sel` in bytes 0 to 3 in that order.
- R10: `bus_rvalid` is high exactly one cycle after `bus_rd`. `bus_rdata` then shows the state as it stood in the read cycle. Global indices below 0x30 that are not mapped read as 0x00.
- R11: An open data-port write to a device-space index other than 0x30, 0x60 or 0x61 raises `dev_wr_stb` for one cycle, one cycle later, carrying the select, the index and the data. A read of such an index returns `dev_rd_data` as sampled in the read cycle.
- R12: When the select is NUM_LDN or above, indices 0x30, 0x60 and 0x61 read 0xFF, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cur_ldn | output | 8 | Current logical-device select |
| cfg_index | output | 8 | Current index, for the function blocks' read mux |
| dev_act | output | NUM_LDN | Activate bit per logical device |
| dev_base | output | 16*NUM_LDN | Base address per logical device |
| pin_sel | output | 32 | Pin-select bytes {0x2B,0x2A,0x29,0x27} |
| dev_wr_stb | output | 1 | Pass-through write strobe to the function blocks |
| dev_wr_ldn | output | 8 | Select that goes with dev_wr_stb |
| dev_wr_index | output | 8 | Index that goes with dev_wr_stb |
| dev_wr_data | output | 8 | Data that goes with dev_wr_stb |
| dev_rd_data | input | 8 | Function-block read data for cur_ldn/cfg_index |

## Verification
The assertions check on every cycle how the open state follows the key writes: the port opens only right after an unlock-key index write, and closes after a lock-key write. They also check that a closed port returns 0xFF and leaves the select and activate bits alone, that read-valid timing holds, and that a pass-through strobe always comes from an open data write. Only the bench's scenarios can show the content of the register file. That covers a key pair broken by an intervening write, banking of the activate and base registers across devices, the identifier bytes surviving writes, select values outside the bank range, and the ordering of the pin-select bytes. The bench's reference model tracks all of this across the whole run.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] IDX_LDN       = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI  = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV       = 8'h22;
  localparam logic [7:0] IDX_VEND_HI   = 8'h23;
  localparam logic [7:0] IDX_VEND_LO   = 8'h24;
  localparam logic [7:0] IDX_ACT       = 8'h30;
  localparam logic [7:0] IDX_BASE_HI   = 8'h60;
  localparam logic [7:0] IDX_BASE_LO   = 8'h61;
  localparam logic [7:0] DEV_SPACE_LO  = 8'h30;

  localparam int NUM_PINSEL = 4;
  // slot 0 is the lowest byte of the pin_sel output
  localparam logic [NUM_PINSEL-1:0][7:0] PINSEL_IDX = {8'h2B, 8'h2A, 8'h29, 8'h27};

  typedef enum logic [1:0] {
    BANK_NONE,
    BANK_ACT,
    BANK_BHI,
    BANK_BLO
  } bank_sel_e;

  function automatic bank_sel_e bank_decode(input logic [7:0] idx);
    case (idx)
      IDX_ACT:     return BANK_ACT;
      IDX_BASE_HI: return BANK_BHI;
      IDX_BASE_LO: return BANK_BLO;
      default:     return BANK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_gate.sv
module cfg_key_gate #(
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic       open_o
);
  logic open_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (!open_q) begin
      if (idx_wr) begin
        if (wdata == UNLOCK_KEY) begin
          if (armed_q) begin
            open_q  <= 1'b1;
            armed_q <= 1'b0;
          end else begin
            armed_q <= 1'b1;
          end
        end else begin
          armed_q <= 1'b0;
        end
      end else if (data_wr) begin
        armed_q <= 1'b0;
      end
    end else if (idx_wr && wdata == LOCK_KEY) begin
      open_q <= 1'b0;
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID    = 16'h5A31,
  parameter logic [7:0]  DEV_REV   = 8'h03,
  parameter logic [15:0] VENDOR_ID = 16'h1934,
  parameter logic [7:0]  LOCK_KEY  = 8'hAA
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    open_i,
  input  logic                    idx_wr,
  input  logic                    data_wr,
  input  logic [7:0]              wdata,
  output logic [7:0]              index_o,
  output logic [7:0]              ldn_o,
  output logic [NUM_PINSEL*8-1:0] pin_sel_o,
  output logic [7:0]              rdata_o
);
  logic [7:0] index_q;
  logic [7:0] ldn_q;
  logic [NUM_PINSEL-1:0][7:0] pin_q;
  logic glob_wr;

  assign glob_wr = data_wr && (index_q < DEV_SPACE_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
    end else if (open_i && idx_wr && wdata != LOCK_KEY) begin
      index_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn_q <= 8'h00;
    end else if (glob_wr && index_q == IDX_LDN) begin
      ldn_q <= wdata;
    end
  end

  for (genvar s = 0; s < NUM_PINSEL; s++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pin_q[s] <= 8'h00;
      end else if (glob_wr && index_q == PINSEL_IDX[s]) begin
        pin_q[s] <= wdata;
      end
    end
    assign pin_sel_o[s*8 +: 8] = pin_q[s];
  end

  always_comb begin
    rdata_o = 8'h00;
    case (index_q)
      IDX_LDN:      rdata_o = ldn_q;
      IDX_DEVID_HI: rdata_o = DEV_ID[15:8];
      IDX_DEVID_LO: rdata_o = DEV_ID[7:0];
      IDX_REV:      rdata_o = DEV_REV;
      IDX_VEND_HI:  rdata_o = VENDOR_ID[15:8];
      IDX_VEND_LO:  rdata_o = VENDOR_ID[7:0];
      default:      rdata_o = 8'h00;
    endcase
    for (int s = 0; s < NUM_PINSEL; s++) begin
      if (index_q == PINSEL_IDX[s]) rdata_o = pin_q[s];
    end
  end

  assign index_o = index_q;
  assign ldn_o   = ldn_q;
endmodule

// File: rtl/cfg_ldn_bank.sv
module cfg_ldn_bank
  import cfg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_i,
  input  logic        wr_i,
  input  bank_sel_e   reg_i,
  input  logic [7:0]  wdata,
  output logic        act_o,
  output logic [15:0] base_o,
  output logic [7:0]  rdata_o
);
  logic        act_q;
  logic [15:0] base_q;
  logic        wr_here;

  assign wr_here = sel_i && wr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= 16'h0000;
    end else if (wr_here) begin
      case (reg_i)
        BANK_ACT: act_q         <= wdata[0];
        BANK_BHI: base_q[15:8]  <= wdata;
        BANK_BLO: base_q[7:0]   <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (sel_i) begin
      case (reg_i)
        BANK_ACT: rdata_o = {7'b0, act_q};
        BANK_BHI: rdata_o = base_q[15:8];
        BANK_BLO: rdata_o = base_q[7:0];
        default:  rdata_o = 8'h00;
      endcase
    end
  end

  assign act_o  = act_q;
  assign base_o = base_q;
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_port_pkg::*;
#(
  parameter int          NUM_LDN    = 8,
  parameter logic [15:0] DEV_ID     = 16'h5A31,
  parameter logic [7:0]  DEV_REV    = 8'h03,
  parameter logic [15:0] VENDOR_ID  = 16'h1934,
  parameter logic [7:0]  UNLOCK_KEY = 8'h87,
  parameter logic [7:0]  LOCK_KEY   = 8'hAA
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic                    bus_addr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic                    bus_rvalid,
  output logic [7:0]              cur_ldn,
  output logic [7:0]              cfg_index,
  output logic [NUM_LDN-1:0]      dev_act,
  output logic [NUM_LDN*16-1:0]   dev_base,
  output logic [NUM_PINSEL*8-1:0] pin_sel,
  output logic                    dev_wr_stb,
  output logic [7:0]              dev_wr_ldn,
  output logic [7:0]              dev_wr_index,
  output logic [7:0]              dev_wr_data,
  input  logic [7:0]              dev_rd_data
);
  localparam logic [8:0] LDN_LIMIT = 9'(NUM_LDN);

  logic       key_open;
  logic       idx_wr;
  logic       data_wr_raw;
  logic       data_wr_ok;
  logic [7:0] glob_rdata;
  logic       in_dev_space;
  logic       ldn_valid;
  bank_sel_e  bank_reg;
  logic       bank_wr;
  logic       pass_wr;
  logic [7:0] bank_rd [NUM_LDN];
  logic [7:0] bank_rd_any;
  logic [7:0] rd_next;

  assign idx_wr      = bus_wr && !bus_addr;
  assign data_wr_raw = bus_wr && bus_addr;
  assign data_wr_ok  = data_wr_raw && key_open;

  cfg_key_gate #(
    .UNLOCK_KEY(UNLOCK_KEY),
    .LOCK_KEY  (LOCK_KEY)
  ) u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (idx_wr),
    .data_wr(data_wr_raw),
    .wdata  (bus_wdata),
    .open_o (key_open)
  );

  cfg_global_regs #(
    .DEV_ID   (DEV_ID),
    .DEV_REV  (DEV_REV),
    .VENDOR_ID(VENDOR_ID),
    .LOCK_KEY (LOCK_KEY)
  ) u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_i   (key_open),
    .idx_wr   (idx_wr),
    .data_wr  (data_wr_ok),
    .wdata    (bus_wdata),
    .index_o  (cfg_index),
    .ldn_o    (cur_ldn),
    .pin_sel_o(pin_sel),
    .rdata_o  (glob_rdata)
  );

  assign in_dev_space = cfg_index >= DEV_SPACE_LO;
  assign ldn_valid    = {1'b0, cur_ldn} < LDN_LIMIT;
  assign bank_reg     = in_dev_space ? bank_decode(cfg_index) : BANK_NONE;
  assign bank_wr      = data_wr_ok && (bank_reg != BANK_NONE);
  assign pass_wr      = data_wr_ok && in_dev_space && (bank_reg == BANK_NONE);

  for (genvar i = 0; i < NUM_LDN; i++) begin : g_bank
    logic        act_w;
    logic [15:0] base_w;
    cfg_ldn_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (cur_ldn == 8'(i)),
      .wr_i   (bank_wr),
      .reg_i  (bank_reg),
      .wdata  (bus_wdata),
      .act_o  (act_w),
      .base_o (base_w),
      .rdata_o(bank_rd[i])
    );
    assign dev_act[i]          = act_w;
    assign dev_base[i*16 +: 16] = base_w;
  end

  always_comb begin
    bank_rd_any = 8'h00;
    for (int i = 0; i < NUM_LDN; i++) bank_rd_any = bank_rd_any | bank_rd[i];
  end

  always_comb begin
    if (!key_open)                  rd_next = 8'hFF;
    else if (!bus_addr)             rd_next = cfg_index;
    else if (!in_dev_space)         rd_next = glob_rdata;
    else if (bank_reg == BANK_NONE) rd_next = dev_rd_data;
    else if (!ldn_valid)            rd_next = 8'hFF;
    else                            rd_next = bank_rd_any;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'h00;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_wr_stb   <= 1'b0;
      dev_wr_ldn   <= 8'h00;
      dev_wr_index <= 8'h00;
      dev_wr_data  <= 8'h00;
    end else begin
      dev_wr_stb <= pass_wr;
      if (pass_wr) begin
        dev_wr_ldn   <= cur_ldn;
        dev_wr_index <= cfg_index;
        dev_wr_data  <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int         NUM_LDN    = 8,
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic               bus_addr,
  input logic [7:0]         bus_wdata,
  input logic [7:0]         bus_rdata,
  input logic               bus_rvalid,
  input logic               open_q,
  input logic [7:0]         cur_ldn,
  input logic [NUM_LDN-1:0] dev_act,
  input logic               dev_wr_stb
);
  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(bus_wr && !bus_addr && bus_wdata == UNLOCK_KEY));

  // R3
  lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && bus_wr && !bus_addr && bus_wdata == LOCK_KEY) |=> !open_q);

  // R4
  closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && bus_rd) |=> (bus_rdata == 8'hFF));

  // R4
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && bus_wr) |=> ($stable(dev_act) && $stable(cur_ldn)));

  // R10
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  // R11
  pass_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr_stb |-> $past(bus_wr && bus_addr && open_q));
endmodule

bind cfg_index_port cfg_port_chk #(
  .NUM_LDN   (NUM_LDN),
  .UNLOCK_KEY(UNLOCK_KEY),
  .LOCK_KEY  (LOCK_KEY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .open_q    (key_open),
  .cur_ldn   (cur_ldn),
  .dev_act   (dev_act),
  .dev_wr_stb(dev_wr_stb)
);

// File: tb/cfg_index_port_tb.sv
module cfg_index_port_tb;
  localparam int          N      = 8;
  localparam logic [15:0] DEVID  = 16'h5A31;
  localparam logic [7:0]  REV    = 8'h03;
  localparam logic [15:0] VEND   = 16'h1934;
  localparam logic [7:0]  UNLOCK = 8'h87;
  localparam logic [7:0]  LOCK   = 8'hAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic [7:0] cur_ldn, cfg_index;
  logic [N-1:0] dev_act;
  logic [N*16-1:0] dev_base;
  logic [31:0] pin_sel;
  logic dev_wr_stb;
  logic [7:0] dev_wr_ldn, dev_wr_index, dev_wr_data;
  logic [7:0] dev_rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign dev_rd_data = cfg_index ^ cur_ldn ^ 8'h5C;

  cfg_index_port #(
    .NUM_LDN(N), .DEV_ID(DEVID), .DEV_REV(REV), .VENDOR_ID(VEND),
    .UNLOCK_KEY(UNLOCK), .LOCK_KEY(LOCK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cur_ldn(cur_ldn), .cfg_index(cfg_index),
    .dev_act(dev_act), .dev_base(dev_base), .pin_sel(pin_sel),
    .dev_wr_stb(dev_wr_stb), .dev_wr_ldn(dev_wr_ldn),
    .dev_wr_index(dev_wr_index), .dev_wr_data(dev_wr_data),
    .dev_rd_data(dev_rd_data)
  );

  // ---------------- reference model ----------------
  bit m_open, m_armed;
  logic [7:0] m_idx, m_ldn;
  logic [N-1:0] m_act;
  logic [N*16-1:0] m_base;
  logic [7:0] m_pin [4];
  bit e_rvalid, e_stb;
  logic [7:0] e_rdata, e_sldn, e_sidx, e_sdat;

  function automatic int pin_slot(input logic [7:0] idx);
    case (idx)
      8'h27: return 0;
      8'h29: return 1;
      8'h2A: return 2;
      8'h2B: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit is_local(input logic [7:0] idx);
    return idx == 8'h30 || idx == 8'h60 || idx == 8'h61;
  endfunction

  function automatic logic [7:0] ref_read(input logic a);
    int l;
    l = int'(m_ldn);
    if (!m_open) return 8'hFF;
    if (!a) return m_idx;
    if (m_idx < 8'h30) begin
      if (pin_slot(m_idx) >= 0) return m_pin[pin_slot(m_idx)];
      case (m_idx)
        8'h07: return m_ldn;
        8'h20: return DEVID[15:8];
        8'h21: return DEVID[7:0];
        8'h22: return REV;
        8'h23: return VEND[15:8];
        8'h24: return VEND[7:0];
        default: return 8'h00;
      endcase
    end
    if (!is_local(m_idx)) return m_idx ^ m_ldn ^ 8'h5C;
    if (l >= N) return 8'hFF;
    if (m_idx == 8'h30) return {7'b0, m_act[l]};
    if (m_idx == 8'h60) return m_base[l*16+8 +: 8];
    return m_base[l*16 +: 8];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_armed = 0; m_idx = 0; m_ldn = 0; m_act = '0; m_base = '0;
      for (int k = 0; k < 4; k++) m_pin[k] = 8'h00;
      e_rvalid = 0; e_stb = 0;
    end else begin
      int l;
      l = int'(m_ldn);
      e_rvalid = bus_rd;
      if (bus_rd) e_rdata = ref_read(bus_addr);
      e_stb = 0;
      if (bus_wr) begin
        if (!m_open) begin
          if (!bus_addr && bus_wdata == UNLOCK) begin
            if (m_armed) begin m_open = 1; m_armed = 0; end
            else m_armed = 1;
          end else m_armed = 0;
        end else if (!bus_addr) begin
          if (bus_wdata == LOCK) m_open = 0;
          else m_idx = bus_wdata;
        end else if (m_idx < 8'h30) begin
          if (m_idx == 8'h07) m_ldn = bus_wdata;
          if (pin_slot(m_idx) >= 0) m_pin[pin_slot(m_idx)] = bus_wdata;
        end else if (is_local(m_idx)) begin
          if (l < N) begin
            if (m_idx == 8'h30) m_act[l] = bus_wdata[0];
            else if (m_idx == 8'h60) m_base[l*16+8 +: 8] = bus_wdata;
            else m_base[l*16 +: 8] = bus_wdata;
          end
        end else begin
          e_stb = 1; e_sldn = m_ldn; e_sidx = m_idx; e_sdat = bus_wdata;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 rvalid", 128'(bus_rvalid), 128'(e_rvalid));
      if (e_rvalid) check("R10 rdata", 128'(bus_rdata), 128'(e_rdata));
      check("R5 cur_ldn", 128'(cur_ldn), 128'(m_ldn));
      check("R7 dev_act", 128'(dev_act), 128'(m_act));
      check("R8 dev_base", 128'(dev_base), 128'(m_base));
      check("R9 pin_sel", 128'(pin_sel),
            128'({m_pin[3], m_pin[2], m_pin[1], m_pin[0]}));
      check("R11 strobe", 128'(dev_wr_stb), 128'(e_stb));
      if (e_stb) check("R11 strobe fields", 128'({dev_wr_ldn, dev_wr_index, dev_wr_data}),
                       128'({e_sldn, e_sidx, e_sdat}));
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, 128'(bus_rdata), 128'(exp));
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx); wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wr(1'b0, idx); rd(1'b1, exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ldn", 128'(cur_ldn), 128'(0));
    check("R1 act", 128'(dev_act), 128'(0));
    check("R1 base", 128'(dev_base), 128'(0));
    check("R1 pinsel", 128'(pin_sel), 128'(0));
    check("R1 index", 128'(cfg_index), 128'(0));
    rd(1'b1, 8'hFF, "R1 closed after reset");

    // R4 closed: writes ignored, reads 0xFF
    wr(1'b0, 8'h07); wr(1'b1, 8'h05);
    check("R4 ldn unchanged", 128'(cur_ldn), 128'(0));
    check("R4 index unchanged", 128'(cfg_index), 128'(0));
    rd(1'b0, 8'hFF, "R4 index port closed");

    // R2 broken sequences
    wr(1'b0, UNLOCK); wr(1'b0, 8'h11); wr(1'b0, UNLOCK);
    wr(1'b1, 8'h00);
    wr(1'b0, UNLOCK);
    rd(1'b1, 8'hFF, "R2 broken key stays closed");
    wr(1'b0, UNLOCK);
    rd(1'b1, 8'h00, "R2 open after key pair");

    // R4 index read while open
    wr(1'b0, 8'h22);
    rd(1'b0, 8'h22, "R4 index readback");

    // R6 identification
    reg_rd(8'h20, DEVID[15:8], "R6 devid hi");
    reg_rd(8'h21, DEVID[7:0], "R6 devid lo");
    reg_rd(8'h22, REV, "R6 rev");
    reg_rd(8'h23, 8'h19, "R6 vendor hi");
    reg_rd(8'h24, 8'h34, "R6 vendor lo");
    reg_wr(8'h20, 8'h00);
    rd(1'b1, DEVID[15:8], "R6 write ignored");

    // R5 select
    reg_wr(8'h07, 8'h03);
    check("R5 cur_ldn", 128'(cur_ldn), 128'(3));
    rd(1'b1, 8'h03, "R5 readback");

    // R7 / R8 banked registers
    reg_wr(8'h30, 8'hFF);
    rd(1'b1, 8'h01, "R7 only bit0");
    check("R7 dev_act bit3", 128'(dev_act), 128'(8'b0000_1000));
    reg_wr(8'h60, 8'h12);
    reg_wr(8'h61, 8'h34);
    check("R8 base dev3", 128'(dev_base[3*16 +: 16]), 128'(16'h1234));
    reg_rd(8'h60, 8'h12, "R8 base hi read");
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h30, 8'h00, "R7 other bank clear");
    reg_wr(8'h61, 8'hC7);
    check("R8 base dev5", 128'(dev_base[5*16 +: 16]), 128'(16'h00C7));
    check("R8 base dev3 kept", 128'(dev_base[3*16 +: 16]), 128'(16'h1234));

    // R9 pin select
    reg_wr(8'h27, 8'hA5);
    reg_wr(8'h29, 8'h5A);
    reg_wr(8'h2A, 8'h0F);
    reg_wr(8'h2B, 8'hF0);
    check("R9 pin_sel order", 128'(pin_sel), 128'(32'hF00F5AA5));
    reg_rd(8'h29, 8'h5A, "R9 readback");

    // R10 unmapped global
    reg_wr(8'h25, 8'h77);
    rd(1'b1, 8'h00, "R10 unmapped reads zero");

    // R11 pass-through
    reg_wr(8'hF5, 8'h3C);
    check("R11 strobe index", 128'(dev_wr_index), 128'(8'hF5));
    check("R11 strobe data", 128'(dev_wr_data), 128'(8'h3C));
    rd(1'b1, 8'hF5 ^ 8'h05 ^ 8'h5C, "R11 pass read");

    // R12 select out of range
    reg_wr(8'h07, 8'h09);
    reg_wr(8'h30, 8'h01);
    check("R12 act unchanged", 128'(dev_act), 128'(8'b0000_1000));
    rd(1'b1, 8'hFF, "R12 reads FF");

    // R3 lock
    wr(1'b0, LOCK);
    check("R3 index kept", 128'(cfg_index), 128'(8'h30));
    rd(1'b1, 8'hFF, "R3 closed after lock");
    wr(1'b0, 8'h07); wr(1'b1, 8'h02);
    check("R4 ldn unchanged after lock", 128'(cur_ldn), 128'(9));

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule